// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit register file and a data memory port that is organised in words. On a load it receives the aligned memory word, the two low address bits and an access code. It returns the value to write back to the register. That value is a selected byte or halfword, sign- or zero-extended, or a partial merge of memory bytes into the old register contents, used for unaligned word access.

On a store it produces the aligned write word and a per-lane write-enable mask. A plain halfword or word access that is not naturally aligned raises a misalignment flag. It then suppresses every write enable and leaves the destination register unchanged.

Byte lanes are big-endian. Address offset 0 is the lane on bits 31:24, and write-enable bit 3 covers that lane. Each accepted request produces exactly one registered response. The response appears one clock later.

Top module: `lsa_unit`

## Requirements
- R1: A request with `req_valid` high produces `rsp_valid` high at the next clock edge, and a cycle without a request produces `rsp_valid` low at the next edge.
- R2: Access code 0 (word load) at offset 0 returns `mem_rdata` unchanged.
- R3: Code 1 (halfword load) returns bits 31:16 at offset 0 and bits 15:0 at offset 2. Code 3 (byte load) returns the lane at bits 31-8*offset down to 24-8*offset. Both sign-extend to 32 bits.
- R4: Codes 2 and 4 are the unsigned halfword and byte loads. They select the same bits as codes 1 and 3 but zero-extend.
- R5: Code 5 (left partial load) at offset k returns `(mem_rdata << 8k)`, with the low 8k bits taken from `reg_old`.
- R6: Code 6 (right partial load) at offset k returns `mem_rdata >> 8(3-k)`, with the high 8(3-k) bits taken from `reg_old`.
- R7: Code 8 (word store) writes `reg_src` with mask 1111. Code 9 (halfword store) replicates the low 16 bits twice, with mask 1100 at offset 0 and 0011 at offset 2. Code 11 (byte store) replicates the low byte four times, with mask 1000 shifted right by the offset.
- R8: Code 13 (left partial store) at offset k writes `reg_src >> 8k` with mask 1111 shifted right by k. Code 14 (right partial store) writes `reg_src << 8(3-k)` with mask 1111 shifted left by 3-k and kept to 4 bits.
- R9: Codes 0, 8 at a nonzero offset, and codes 1, 2, 9 at an odd offset, raise `rsp_misalign`. The response then has mask 0000 and write word 0, and loads return `reg_old`.
- R10: Loads give mask 0000 and write word 0. Stores give a load result of 0. Codes 7, 10, 12 and 15 are reserved: they return `reg_old`, mask 0000, write word 0 and no misalignment.
- R11: After reset, `rsp_valid`, `rsp_ld_data`, `rsp_wdata`, `rsp_be` and `rsp_misalign` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Access code; bit 3 set for stores |
| req_addr_lo | input | 2 | Byte offset within the word |
| mem_rdata | input | 32 | Aligned memory word for loads |
| reg_old | input | 32 | Current destination register value for merging loads |
| reg_src | input | 32 | Source register value for stores |
| rsp_valid | output | 1 | Response present |
| rsp_ld_data | output | 32 | Register write-back value |
| rsp_wdata | output | 32 | Aligned memory write word |
| rsp_be | output | 4 | Lane write enables; bit 3 covers bits 31:24 |
| rsp_misalign | output | 1 | Natural-alignment violation |

## Verification
A wrong lane index or shift amount in either path shows up on the first response for the affected code and offset. It appears one clock after the request, as a misplaced byte or a wrong enable bit. The bench therefore drives every code at every offset with patterns whose bytes all differ and whose sign bits vary. A stale response register would show as a duplicate or missing `rsp_valid` in the cycle right after an idle slot. A broken misalignment decode shows as nonzero enables, or as a changed register, on the very response that should have been suppressed.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [3:0] {
    OP_LW   = 4'd0,
    OP_LH   = 4'd1,
    OP_LHU  = 4'd2,
    OP_LB   = 4'd3,
    OP_LBU  = 4'd4,
    OP_LWL  = 4'd5,
    OP_LWR  = 4'd6,
    OP_RSV7 = 4'd7,
    OP_SW   = 4'd8,
    OP_SH   = 4'd9,
    OP_RSVA = 4'd10,
    OP_SB   = 4'd11,
    OP_RSVC = 4'd12,
    OP_SWL  = 4'd13,
    OP_SWR  = 4'd14,
    OP_RSVF = 4'd15
  } lsa_op_e;
endpackage

// File: rtl/lsa_rst_sync.sv
module lsa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lsa_load_path.sv
module lsa_load_path
  import lsa_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFS_W = $clog2(LANES)
) (
  input  lsa_op_e           op,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] mem_word,
  input  logic [DATA_W-1:0] old_word,
  output logic [DATA_W-1:0] ld_data,
  output logic              misalign
);
  logic [7:0] mem_b [LANES];
  logic [7:0] old_b [LANES];
  logic [7:0] res_b [LANES];
  logic [DATA_W-1:0] ext_word;
  logic              use_ext;

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign mem_b[g] = mem_word[DATA_W-1-8*g -: 8];
    assign old_b[g] = old_word[DATA_W-1-8*g -: 8];
  end

  always_comb begin
    int unsigned k;
    int unsigned rshift;
    logic [15:0] half;
    logic [7:0]  byt;
    k        = int'(ofs);
    rshift   = LANES - 1 - k;
    misalign = 1'b0;
    use_ext  = 1'b0;
    ext_word = '0;
    half     = '0;
    byt      = '0;
    for (int i = 0; i < LANES; i++) res_b[i] = old_b[i];
    case (op)
      OP_LW: begin
        if (ofs != '0) misalign = 1'b1;
        else for (int i = 0; i < LANES; i++) res_b[i] = mem_b[i];
      end
      OP_LH, OP_LHU: begin
        if (ofs[0]) misalign = 1'b1;
        else begin
          half     = {mem_b[k], mem_b[(k+1) % LANES]};
          use_ext  = 1'b1;
          ext_word = {{(DATA_W-16){(op == OP_LH) & half[15]}}, half};
        end
      end
      OP_LB, OP_LBU: begin
        byt      = mem_b[k];
        use_ext  = 1'b1;
        ext_word = {{(DATA_W-8){(op == OP_LB) & byt[7]}}, byt};
      end
      OP_LWL: begin
        for (int i = 0; i < LANES; i++)
          if (i + k < LANES) res_b[i] = mem_b[i+k];
      end
      OP_LWR: begin
        for (int i = 0; i < LANES; i++)
          if (i >= rshift) res_b[i] = mem_b[i-rshift];
      end
      OP_SW, OP_SH, OP_SB, OP_SWL, OP_SWR: begin
        for (int i = 0; i < LANES; i++) res_b[i] = '0;
      end
      default: ;
    endcase
  end

  always_comb begin
    ld_data = ext_word;
    if (!use_ext)
      for (int i = 0; i < LANES; i++) ld_data[DATA_W-1-8*i -: 8] = res_b[i];
  end
endmodule

// File: rtl/lsa_store_path.sv
module lsa_store_path
  import lsa_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFS_W = $clog2(LANES)
) (
  input  lsa_op_e           op,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] src_word,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic              misalign
);
  logic [7:0] src_b [LANES];
  logic [7:0] out_b [LANES];
  logic       lane_en [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign src_b[g] = src_word[DATA_W-1-8*g -: 8];
  end

  always_comb begin
    int unsigned k;
    int unsigned rshift;
    k        = int'(ofs);
    rshift   = LANES - 1 - k;
    misalign = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      out_b[i]   = '0;
      lane_en[i] = 1'b0;
    end
    case (op)
      OP_SW: begin
        if (ofs != '0) misalign = 1'b1;
        else for (int i = 0; i < LANES; i++) begin
          out_b[i]   = src_b[i];
          lane_en[i] = 1'b1;
        end
      end
      OP_SH: begin
        if (ofs[0]) misalign = 1'b1;
        else for (int i = 0; i < LANES; i++) begin
          out_b[i]   = src_b[LANES-2 + (i % 2)];
          lane_en[i] = (i == k) || (i == k + 1);
        end
      end
      OP_SB: begin
        for (int i = 0; i < LANES; i++) begin
          out_b[i]   = src_b[LANES-1];
          lane_en[i] = (i == k);
        end
      end
      OP_SWL: begin
        for (int i = 0; i < LANES; i++)
          if (i >= k) begin
            out_b[i]   = src_b[i-k];
            lane_en[i] = 1'b1;
          end
      end
      OP_SWR: begin
        for (int i = 0; i < LANES; i++)
          if (i <= k) begin
            out_b[i]   = src_b[i+rshift];
            lane_en[i] = 1'b1;
          end
      end
      default: ;
    endcase
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      wdata[DATA_W-1-8*i -: 8] = out_b[i];
      be[LANES-1-i]            = lane_en[i];
    end
  end
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
  import lsa_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFS_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [OFS_W-1:0]  req_addr_lo,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] reg_old,
  input  logic [DATA_W-1:0] reg_src,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_ld_data,
  output logic [DATA_W-1:0] rsp_wdata,
  output logic [LANES-1:0]  rsp_be,
  output logic              rsp_misalign
);
  logic              rst_sync_n;
  lsa_op_e           op;
  logic [DATA_W-1:0] ld_d, wd_d;
  logic [LANES-1:0]  be_d;
  logic              ld_mis, st_mis;
  logic [DATA_W-1:0] ld_n, wd_n;
  logic [LANES-1:0]  be_n;
  logic              mis_n, vld_n;
  logic [3:0]        op_q, op_n;

  assign op = lsa_op_e'(req_op);

  lsa_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  lsa_load_path #(.DATA_W(DATA_W)) u_load (
    .op(op), .ofs(req_addr_lo), .mem_word(mem_rdata), .old_word(reg_old),
    .ld_data(ld_d), .misalign(ld_mis)
  );

  lsa_store_path #(.DATA_W(DATA_W)) u_store (
    .op(op), .ofs(req_addr_lo), .src_word(reg_src),
    .wdata(wd_d), .be(be_d), .misalign(st_mis)
  );

  // next-state: capture on request, hold otherwise
  always_comb begin
    vld_n = req_valid;
    ld_n  = rsp_ld_data;
    wd_n  = rsp_wdata;
    be_n  = rsp_be;
    mis_n = rsp_misalign;
    op_n  = op_q;
    if (req_valid) begin
      ld_n  = ld_d;
      wd_n  = wd_d;
      be_n  = be_d;
      mis_n = ld_mis | st_mis;
      op_n  = req_op;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid    <= 1'b0;
      rsp_ld_data  <= '0;
      rsp_wdata    <= '0;
      rsp_be       <= '0;
      rsp_misalign <= 1'b0;
      op_q         <= '0;
    end else begin
      rsp_valid    <= vld_n;
      rsp_ld_data  <= ld_n;
      rsp_wdata    <= wd_n;
      rsp_be       <= be_n;
      rsp_misalign <= mis_n;
      op_q         <= op_n;
    end
  end

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);
  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid);
  // R9
  misalign_kills_be_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_misalign |-> (rsp_be == '0));
  // R4
  unsigned_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && op_q == 4'(OP_LBU)) |-> (rsp_ld_data[DATA_W-1:8] == '0));
  // R7
  byte_store_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && op_q == 4'(OP_SB)) |-> ($countones(rsp_be) == 1));
  // R10
  load_no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && !op_q[3]) |-> (rsp_be == '0));
endmodule

// File: tb/tb_lsa_unit.sv
module tb_lsa_unit;
  typedef struct {
    logic [31:0] ld;
    logic [31:0] wd;
    logic [3:0]  be;
    logic        mis;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = '0;
  logic [1:0]  req_addr_lo = '0;
  logic [31:0] mem_rdata = '0, reg_old = '0, reg_src = '0;
  logic        rsp_valid, rsp_misalign;
  logic [31:0] rsp_ld_data, rsp_wdata;
  logic [3:0]  rsp_be;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  lsa_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr_lo(req_addr_lo), .mem_rdata(mem_rdata), .reg_old(reg_old),
    .reg_src(reg_src), .rsp_valid(rsp_valid), .rsp_ld_data(rsp_ld_data),
    .rsp_wdata(rsp_wdata), .rsp_be(rsp_be), .rsp_misalign(rsp_misalign)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(int op, int k, logic [31:0] m, logic [31:0] o, logic [31:0] s);
    exp_t e;
    int sh;
    e.ld = 32'h0; e.wd = 32'h0; e.be = 4'h0; e.mis = 1'b0;
    case (op)
      0: begin e.tag = "R2"; e.ld = m; end
      1, 2: begin
        logic [15:0] h;
        e.tag = (op == 1) ? "R3" : "R4";
        h = 16'(m >> (16 - 8*k));
        e.ld = (op == 1) ? {{16{h[15]}}, h} : {16'h0, h};
      end
      3, 4: begin
        logic [7:0] b;
        e.tag = (op == 3) ? "R3" : "R4";
        b = 8'(m >> (8*(3-k)));
        e.ld = (op == 3) ? {{24{b[7]}}, b} : {24'h0, b};
      end
      5: begin sh = 8*k; e.tag = "R5"; e.ld = (m << sh) | (o & ~(32'hFFFF_FFFF << sh)); end
      6: begin sh = 8*(3-k); e.tag = "R6"; e.ld = (m >> sh) | (o & ~(32'hFFFF_FFFF >> sh)); end
      8: begin e.tag = "R7"; e.wd = s; e.be = 4'hF; end
      9: begin e.tag = "R7"; e.wd = {2{s[15:0]}}; e.be = (k == 0) ? 4'b1100 : 4'b0011; end
      11: begin e.tag = "R7"; e.wd = {4{s[7:0]}}; e.be = 4'b1000 >> k; end
      13: begin e.tag = "R8"; e.wd = s >> (8*k); e.be = 4'b1111 >> k; end
      14: begin e.tag = "R8"; e.wd = s << (8*(3-k)); e.be = 4'((4'b1111 << (3-k))); end
      default: begin e.tag = "R10"; e.ld = o; end
    endcase
    if (((op == 0 || op == 8) && k != 0) || ((op == 1 || op == 2 || op == 9) && k[0])) begin
      e.tag = "R9"; e.mis = 1'b1; e.wd = 32'h0; e.be = 4'h0;
      e.ld = (op < 8) ? o : 32'h0;
    end
    return e;
  endfunction

  task automatic send(int op, int k, logic [31:0] m, logic [31:0] o, logic [31:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_op = 4'(op); req_addr_lo = 2'(k);
    mem_rdata = m; reg_old = o; reg_src = s;
    sb_q.push_back(model(op, k, m, o, s));
  endtask

  task automatic idle_check();
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    // R1: no response one edge after an idle cycle
    check("R1", "rsp_valid after idle", {31'h0, rsp_valid}, 32'h0);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        check("R1", "unexpected response", 32'h1, 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, "ld_data", rsp_ld_data, e.ld);
        check(e.tag, "wdata", rsp_wdata, e.wd);
        check(e.tag, "be", {28'h0, rsp_be}, {28'h0, e.be});
        check(e.tag, "misalign", {31'h0, rsp_misalign}, {31'h0, e.mis});
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    check("R11", "rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check("R11", "rsp_ld_data", rsp_ld_data, 32'h0);
    check("R11", "rsp_wdata", rsp_wdata, 32'h0);
    check("R11", "rsp_be", {28'h0, rsp_be}, 32'h0);
    check("R11", "rsp_misalign", {31'h0, rsp_misalign}, 32'h0);
    for (int op = 0; op < 16; op++)
      for (int k = 0; k < 4; k++) begin
        send(op, k, 32'h81F2_6A3C, 32'hD5C4_B3A2, 32'h9E7D_5B1C);
        send(op, k, 32'h17E8_45B9, 32'h0112_2334, 32'h4A8B_C6F7);
      end
    idle_check();
    send(5, 1, 32'hAABB_CCDD, 32'h1122_3344, 32'h0);
    send(6, 2, 32'hAABB_CCDD, 32'h1122_3344, 32'h0);
    idle_check();
    send(13, 3, 32'h0, 32'h0, 32'hCAFE_F00D);
    send(14, 0, 32'h0, 32'h0, 32'hCAFE_F00D);
    idle_check();
    repeat (3) @(negedge clk);
    // R1: every request answered
    check("R1", "pending responses", sb_q.size(), 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule